// File: doc/BRIEF.md
# Quadrature Mixer with Selectable Peak Gain

This block turns one baseband in-phase/quadrature sample pair into one real output sample. Each cycle it multiplies the in-phase sample by a cosine carrier value and the quadrature sample by a sine carrier value. It adds the two products and halves the sum. It then multiplies the result by one of four fixed gains, so that the peak of the mixed signal can be brought back to full scale for the carrier frequency in use. A control bit negates the sine value before mixing, which flips the output to the other sideband in single-sideband use.

All operands are two's-complement fractions of `DW` bits. The carrier comes from an external oscillator. The gain code and the spectrum-reverse bit are sampled together with the data, so they may change on any cycle. A valid flag travels beside the data through a fixed three-stage pipeline. The output saturates rather than wrapping.

Top module: `iq_gain_mixer`

## Requirements
- R1: With Sn the sine value after the optional negation, the mixed value is M = floor((I*C + Q*Sn) / 2^DW). This is the product scaled back to DW-bit fraction format and then halved.
- R2: Gain code 2'b00 multiplies M by 45/32 (1.40625).
- R3: Gain code 2'b01 multiplies M by 64/32 (2.0), which is the unity gain for a carrier at one quarter of the sample rate.
- R4: Gain code 2'b10 multiplies M by 51/32 (1.59375).
- R5: Gain code 2'b11 multiplies M by 45/32 (1.40625), the same as code 2'b00.
- R6: When spec_rev is 1, the sine value is negated before mixing. Negating the most negative sine value gives the exact positive value and does not wrap.
- R7: The gain product is taken with 5 fractional bits and rounded toward negative infinity: Y = floor(M*G/32). A non-negative M gives a non-negative output, and a negative M gives a negative output.
- R8: Y is clamped to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1] and never wraps.
- R9: out_valid and out_sample appear exactly 3 clock edges after the inputs are sampled. out_valid equals in_valid from 3 cycles earlier, including idle gaps.
- R10: A synchronous active-high rst clears out_valid and out_sample to 0 and discards any samples in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | DW | Signed in-phase sample |
| in_q | input | DW | Signed quadrature sample |
| carrier_cos | input | DW | Signed cosine carrier value |
| carrier_sin | input | DW | Signed sine carrier value |
| gain_sel | input | 2 | Gain code (see R2 to R5) |
| spec_rev | input | 1 | Negate the sine value (reverse spectrum) |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | DW | Saturated signed mixed sample |

## Verification
The assertions check four things on every cycle: the three-cycle valid alignment, the clearing of the valid flags after reset, the preservation of sign across the gain stage, and a zero output for a zero input pair. The exact arithmetic can only be shown by the bench's sweeps, which compare results against values computed independently. Those sweeps cover each of the four gain factors, the negation of the most negative sine value under spectrum reversal, rounding on negative values, and saturation at both rails.

// File: rtl/iq_mix_pkg.sv
package iq_mix_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int GAIN_FRAC  = 5;
    localparam int GAIN_W     = 8;

    typedef enum logic [1:0] {
        GAIN_A = 2'b00,
        GAIN_B = 2'b01,
        GAIN_C = 2'b10,
        GAIN_D = 2'b11
    } gain_sel_e;

    typedef struct packed {
        logic      vld;
        gain_sel_e gsel;
    } lane_ctl_t;

    // Gain factor in Q2.5, unsigned
    function automatic logic [GAIN_W-1:0] gain_q5(input gain_sel_e s);
        logic [GAIN_W-1:0] g;
        case (s)
            GAIN_A:  g = 8'd45;
            GAIN_B:  g = 8'd64;
            GAIN_C:  g = 8'd51;
            default: g = 8'd45;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/iq_mix_prod.sv
module iq_mix_prod
    import iq_mix_pkg::*;
#(
    parameter int DW  = SAMPLE_W,
    localparam int XW = DW + 1,
    localparam int PW = 2 * XW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lane_ctl_t            ctl_in,
    input  logic signed [DW-1:0] smp_i,
    input  logic signed [DW-1:0] smp_q,
    input  logic signed [DW-1:0] car_c,
    input  logic signed [DW-1:0] car_s,
    input  logic                 rev,
    output lane_ctl_t            ctl_out,
    output logic signed [PW-1:0] prod_i,
    output logic signed [PW-1:0] prod_q
);

    logic signed [XW-1:0] i_x, q_x, c_x, s_x, s_sel;

    always_comb begin
        i_x   = {smp_i[DW-1], smp_i};
        q_x   = {smp_q[DW-1], smp_q};
        c_x   = {car_c[DW-1], car_c};
        s_x   = {car_s[DW-1], car_s};
        // one extra bit keeps the negation of the most negative value exact
        s_sel = rev ? -s_x : s_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_out <= '{vld: 1'b0, gsel: GAIN_A};
            prod_i  <= '0;
            prod_q  <= '0;
        end else begin
            ctl_out <= ctl_in;
            prod_i  <= PW'(i_x) * PW'(c_x);
            prod_q  <= PW'(q_x) * PW'(s_sel);
        end
    end

    a_r10_prod_clear: assert property (@(posedge clk) rst |=> !ctl_out.vld)
        else $error("a_r10_prod_clear");

endmodule

// File: rtl/iq_mix_half.sv
module iq_mix_half
    import iq_mix_pkg::*;
#(
    parameter int DW  = SAMPLE_W,
    localparam int PW = 2 * (DW + 1),
    localparam int SW = PW + 1,
    localparam int HW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lane_ctl_t            ctl_in,
    input  logic signed [PW-1:0] prod_i,
    input  logic signed [PW-1:0] prod_q,
    output lane_ctl_t            ctl_out,
    output logic signed [HW-1:0] half
);

    logic signed [SW-1:0] sum_w;

    always_comb begin
        sum_w = SW'(prod_i) + SW'(prod_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_out <= '{vld: 1'b0, gsel: GAIN_A};
            half    <= '0;
        end else begin
            ctl_out <= ctl_in;
            // dropping DW low bits rescales and halves, flooring
            half    <= sum_w[DW +: HW];
        end
    end

endmodule

// File: rtl/iq_mix_gain.sv
module iq_mix_gain
    import iq_mix_pkg::*;
#(
    parameter int DW  = SAMPLE_W,
    localparam int HW = DW + 2,
    localparam int MW = HW + GAIN_W,
    localparam int FW = MW - GAIN_FRAC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lane_ctl_t            ctl_in,
    input  logic signed [HW-1:0] half,
    output logic                 vld_out,
    output logic signed [DW-1:0] y
);

    localparam logic signed [FW-1:0] YMAX = FW'((2 ** (DW - 1)) - 1);
    localparam logic signed [FW-1:0] YMIN = -FW'(2 ** (DW - 1));

    logic signed [MW-1:0] h_x, g_x, scaled;
    logic signed [FW-1:0] floored;
    logic signed [DW-1:0] clamped;

    always_comb begin
        h_x     = MW'(half);
        g_x     = MW'($signed({1'b0, gain_q5(ctl_in.gsel)}));
        scaled  = h_x * g_x;
        floored = scaled[MW-1:GAIN_FRAC];
        if (floored > YMAX)
            clamped = YMAX[DW-1:0];
        else if (floored < YMIN)
            clamped = YMIN[DW-1:0];
        else
            clamped = floored[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_out <= 1'b0;
            y       <= '0;
        end else begin
            vld_out <= ctl_in.vld;
            y       <= clamped;
        end
    end

    a_r7_sign_pos: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.vld && !half[HW-1]) |=> !y[DW-1])
        else $error("a_r7_sign_pos");

    a_r7_sign_neg: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.vld && half[HW-1]) |=> y[DW-1])
        else $error("a_r7_sign_neg");

endmodule

// File: rtl/iq_gain_mixer.sv
module iq_gain_mixer
    import iq_mix_pkg::*;
#(
    parameter int DW  = SAMPLE_W,
    localparam int PW = 2 * (DW + 1),
    localparam int HW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [DW-1:0] carrier_cos,
    input  logic signed [DW-1:0] carrier_sin,
    input  logic [1:0]           gain_sel,
    input  logic                 spec_rev,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);

    lane_ctl_t            ctl0, ctl1, ctl2;
    logic signed [PW-1:0] p_i, p_q;
    logic signed [HW-1:0] h;

    always_comb begin
        ctl0.vld  = in_valid;
        ctl0.gsel = gain_sel_e'(gain_sel);
    end

    iq_mix_prod #(.DW(DW)) u_prod (
        .clk(clk), .rst(rst), .ctl_in(ctl0),
        .smp_i(in_i), .smp_q(in_q), .car_c(carrier_cos), .car_s(carrier_sin),
        .rev(spec_rev), .ctl_out(ctl1), .prod_i(p_i), .prod_q(p_q)
    );

    iq_mix_half #(.DW(DW)) u_half (
        .clk(clk), .rst(rst), .ctl_in(ctl1),
        .prod_i(p_i), .prod_q(p_q), .ctl_out(ctl2), .half(h)
    );

    iq_mix_gain #(.DW(DW)) u_gain (
        .clk(clk), .rst(rst), .ctl_in(ctl2), .half(h),
        .vld_out(out_valid), .y(out_sample)
    );

    // cycles since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)))
        else $error("a_r9_latency");

    a_r1_zero_in: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_i == '0 && in_q == '0) |=> ##2 (out_sample == '0))
        else $error("a_r1_zero_in");

endmodule

// File: tb/iq_gain_mixer_test.sv
module iq_gain_mixer_test;

    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0, in_q = '0, carrier_cos = '0, carrier_sin = '0;
    logic [1:0] gain_sel = 2'b00;
    logic spec_rev = 1'b0;
    logic out_valid;
    logic signed [DW-1:0] out_sample;

    always #2ns clk = ~clk;

    iq_gain_mixer #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .carrier_cos(carrier_cos), .carrier_sin(carrier_sin), .gain_sel(gain_sel),
        .spec_rev(spec_rev), .out_valid(out_valid), .out_sample(out_sample)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic   hv_v[3];
    longint hv_d[3];
    string  hv_t[3];

    // Model of R1..R8 in plain integer arithmetic
    function automatic longint model(longint i, longint q, longint c, longint s,
                                     bit rev, int g, output string tag);
        longint sn, sum, m, t, gv;
        sn  = rev ? -s : s;                 // R6
        sum = i * c + q * sn;
        m   = sum >>> DW;                   // R1 floor
        case (g)
            0: begin gv = 45; tag = "R2"; end
            1: begin gv = 64; tag = "R3"; end
            2: begin gv = 51; tag = "R4"; end
            default: begin gv = 45; tag = "R5"; end
        endcase
        if (rev) tag = "R6";
        t = (m * gv) >>> 5;                 // R7 floor
        if (t < 0 && (m * gv) % 32 != 0) tag = "R7";
        if (t > 32767) begin t = 32767; tag = "R8"; end
        if (t < -32768) begin t = -32768; tag = "R8"; end
        return t;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int k = 0; k < 3; k++) begin hv_v[k] = 0; hv_d[k] = 0; hv_t[k] = "R9"; end
    endtask

    // One cycle: check output due now, then drive new inputs
    task automatic step(bit v, longint i, longint q, longint c, longint s, bit rev, int g);
        string tg;
        longint e;
        @(negedge clk);
        check(out_valid == hv_v[2], "R9", longint'(out_valid), longint'(hv_v[2]));
        if (hv_v[2])
            check(longint'(out_sample) == hv_d[2], hv_t[2], longint'(out_sample), hv_d[2]);
        e = model(i, q, c, s, rev, g, tg);
        hv_v[2] = hv_v[1]; hv_d[2] = hv_d[1]; hv_t[2] = hv_t[1];
        hv_v[1] = hv_v[0]; hv_d[1] = hv_d[0]; hv_t[1] = hv_t[0];
        hv_v[0] = v; hv_d[0] = e; hv_t[0] = tg;
        in_valid = v; in_i = DW'(i); in_q = DW'(q);
        carrier_cos = DW'(c); carrier_sin = DW'(s);
        spec_rev = rev; gain_sel = 2'(g);
    endtask

    longint vals[7] = '{-32768, -16384, -1, 0, 1, 12345, 32767};

    initial begin
        clear_hist();
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10", longint'(out_valid), 0);
        check(out_sample == '0, "R10", longint'(out_sample), 0);
        rst = 1'b0;

        // near-exhaustive sweep over gain codes, reverse bit and corner values
        begin
            int n = 0;
            for (int g = 0; g < 4; g++)
                for (int r = 0; r < 2; r++)
                    for (int a = 0; a < 7; a++)
                        for (int b = 0; b < 7; b++)
                            for (int c = 0; c < 7; c++)
                                for (int d = 0; d < 7; d++) begin
                                    step(1'b1, vals[a], vals[b], vals[c], vals[d], r[0], g);
                                    n++;
                                    if (n % 97 == 0) step(1'b0, 0, 0, 0, 0, 0, 0); // R9 gap
                                end
        end
        // R3 quarter-rate carrier at full scale, R6 extreme negation
        step(1'b1, 32767, 0, 32767, 0, 0, 1);
        step(1'b1, 0, -32768, 0, -32768, 1, 1);
        step(1'b1, -32768, 0, 32767, 0, 0, 2);
        step(1'b1, -3, 5, 7, -9, 0, 3);
        repeat (4) step(1'b0, 0, 0, 0, 0, 0, 0);

        // R10: reset discards samples in flight
        step(1'b1, 20000, 20000, 20000, 20000, 0, 1);
        step(1'b1, 20000, 20000, 20000, 20000, 0, 1);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", longint'(out_valid), 0);
        check(out_sample == '0, "R10", longint'(out_sample), 0);
        rst = 1'b0;
        clear_hist();
        repeat (4) step(1'b0, 0, 0, 0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule